// File: doc/BRIEF.md
# TMR Recovery Sequencer

This block sits behind the voter of a triple-redundant unit and decides how to recover when the three copies fail to produce a majority. The voter reports each result with a one-cycle strobe and a flag that says whether a majority was found. Most upsets are transient. The first response to a lost majority is therefore a cheap re-execution of the same task on the same hardware, requested with a one-cycle pulse. The sequencer then waits for the next voted result.

Each re-execution that again ends without a majority adds one to a failure counter and one programmed cost step to a cost accumulator. The sequencer stops retrying and asks for a hardware swap in two cases: when the failure count rises above the programmed limit, or when the accumulated retry cost rises above the programmed swap cost. After the swap completes, it asks for a reload and restart and waits until that is acknowledged. A voted result with a majority, or a finished restart, clears both the counter and the accumulator and returns the block to idle.

The limit and the two cost values are plain inputs. They are captured only while reset is held.

Top module: `tmr_recovery_ctrl`

## Requirements
- R1: While and right after reset, `rerun_req`, `swap_req` and `restart_req` are low and `retry_cnt` is 0.
- R2: A strobe with `vote_agree`=0 received while idle raises `rerun_req` for exactly one cycle, starting the cycle after that strobe. `retry_cnt` stays unchanged.
- R3: A strobe with `vote_agree`=1 received while waiting for a re-execution result returns the block to idle and clears `retry_cnt` to 0. No request is raised.
- R4: A strobe with `vote_agree`=0 received while waiting for a result adds 1 to `retry_cnt`, saturating at all ones. If neither escalation limit is crossed, a new one-cycle `rerun_req` pulse follows in the next cycle.
- R5: If the failure count after that increment is strictly greater than the captured limit, the block raises a one-cycle `swap_req` pulse instead of `rerun_req`.
- R6: If the accumulated cost after adding one cost step is strictly greater than the captured swap cost, the block raises a one-cycle `swap_req` pulse instead of `rerun_req`. The accumulator starts at 0 after reset and after every clear.
- R7: After `swap_req`, the block waits for a `swap_done` pulse. It then holds `restart_req` high until `restart_done` is seen, after which it goes idle with `retry_cnt`=0.
- R8: The limit and the two cost inputs are captured only while `rst_n` is low. Changing them afterwards has no effect on escalation.
- R9: Voter strobes received while a swap or restart is in progress are ignored. They raise no request and leave `retry_cnt` unchanged.
- R10: At most one of `rerun_req`, `swap_req` and `restart_req` is high in any cycle.
- R11: A strobe with `vote_agree`=1 received while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the configuration is captured while it is low |
| cfg_retry_limit | input | CW | Number of failed re-executions allowed before a swap |
| cfg_retry_cost | input | KW | Cost added for each failed re-execution |
| cfg_swap_cost | input | KW | Cost of a hardware swap |
| vote_valid | input | 1 | Voter result strobe |
| vote_agree | input | 1 | 1 = majority found, 0 = no majority |
| swap_done | input | 1 | Swap finished |
| restart_done | input | 1 | Reload and restart finished |
| rerun_req | output | 1 | One-cycle request to re-execute the task |
| swap_req | output | 1 | One-cycle request to swap the hardware |
| restart_req | output | 1 | Held request to reload and restart |
| retry_cnt | output | CW | Failed re-executions since the last clear |

## Verification
Every request output is decoded from the state register. A voter strobe or done pulse sampled at one rising edge therefore shows its effect, both the new request level and the updated `retry_cnt`, in the cycle that follows that edge. The bench drives each stimulus for one cycle on a falling edge. It samples the outputs on the next falling edge, which is exactly one rising edge later. It checks the end of each one-cycle pulse on the falling edge after that. The expected count and the escalation decision come from a bench model that is stepped on the same strobes.

// File: rtl/tmr_rec_pkg.sv
package tmr_rec_pkg;
  typedef enum logic [2:0] {
    RS_IDLE      = 3'd0,
    RS_RERUN     = 3'd1,
    RS_AWAIT     = 3'd2,
    RS_SWAP      = 3'd3,
    RS_SWAP_WAIT = 3'd4,
    RS_RESTART   = 3'd5
  } rec_state_e;
endpackage

// File: rtl/tmr_rec_budget.sv
// Failure counter and retry-cost accumulator with the escalation decision.
module tmr_rec_budget #(
  parameter int CW = 4,
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_limit,
  input  logic [KW-1:0] cfg_step,
  input  logic [KW-1:0] cfg_swap,
  input  logic          bump,
  input  logic          clear,
  output logic [CW-1:0] fail_cnt,
  output logic          escalate
);
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};
  localparam logic [KW-1:0] ACC_TOP = {KW{1'b1}};

  logic [CW-1:0] lim_q, cnt_q;
  logic [KW-1:0] step_q, swap_q, acc_q;
  logic [CW:0]   cnt_inc;
  logic [KW:0]   acc_sum;

  // One bit wider than the registers so the comparison cannot wrap.
  assign cnt_inc  = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign acc_sum  = {1'b0, acc_q} + {1'b0, step_q};
  assign escalate = (cnt_inc > {1'b0, lim_q}) || (acc_sum > {1'b0, swap_q});
  assign fail_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q  <= cfg_limit;
      step_q <= cfg_step;
      swap_q <= cfg_swap;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (clear) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (bump) begin
      cnt_q <= cnt_inc[CW] ? CNT_TOP : cnt_inc[CW-1:0];
      acc_q <= acc_sum[KW] ? ACC_TOP : acc_sum[KW-1:0];
    end
  end
endmodule

// File: rtl/tmr_rec_fsm.sv
// Recovery sequence: re-execute, await verdict, escalate to swap and restart.
module tmr_rec_fsm
  import tmr_rec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vote_valid,
  input  logic vote_agree,
  input  logic swap_done,
  input  logic restart_done,
  input  logic escalate,
  output logic bump,
  output logic clear,
  output logic rerun_req,
  output logic swap_req,
  output logic restart_req
);
  rec_state_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    bump  = 1'b0;
    clear = 1'b0;
    unique case (st_q)
      RS_IDLE: if (vote_valid && !vote_agree) st_d = RS_RERUN;
      RS_RERUN: st_d = RS_AWAIT;
      RS_AWAIT: begin
        if (vote_valid) begin
          if (vote_agree) begin
            clear = 1'b1;
            st_d  = RS_IDLE;
          end else begin
            bump = 1'b1;
            st_d = escalate ? RS_SWAP : RS_RERUN;
          end
        end
      end
      RS_SWAP: st_d = RS_SWAP_WAIT;
      RS_SWAP_WAIT: if (swap_done) st_d = RS_RESTART;
      RS_RESTART: begin
        if (restart_done) begin
          clear = 1'b1;
          st_d  = RS_IDLE;
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  assign rerun_req   = (st_q == RS_RERUN);
  assign swap_req    = (st_q == RS_SWAP);
  assign restart_req = (st_q == RS_RESTART);
endmodule

// File: rtl/tmr_recovery_ctrl.sv
module tmr_recovery_ctrl #(
  parameter int CW = 4,
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_retry_limit,
  input  logic [KW-1:0] cfg_retry_cost,
  input  logic [KW-1:0] cfg_swap_cost,
  input  logic          vote_valid,
  input  logic          vote_agree,
  input  logic          swap_done,
  input  logic          restart_done,
  output logic          rerun_req,
  output logic          swap_req,
  output logic          restart_req,
  output logic [CW-1:0] retry_cnt
);
  logic bump, clear, escalate;

  tmr_rec_budget #(.CW(CW), .KW(KW)) u_budget (
    .clk(clk), .rst_n(rst_n),
    .cfg_limit(cfg_retry_limit), .cfg_step(cfg_retry_cost), .cfg_swap(cfg_swap_cost),
    .bump(bump), .clear(clear), .fail_cnt(retry_cnt), .escalate(escalate)
  );

  tmr_rec_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .vote_valid(vote_valid), .vote_agree(vote_agree),
    .swap_done(swap_done), .restart_done(restart_done),
    .escalate(escalate), .bump(bump), .clear(clear),
    .rerun_req(rerun_req), .swap_req(swap_req), .restart_req(restart_req)
  );
endmodule

// File: rtl/tmr_recovery_chk.sv
module tmr_recovery_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart_done,
  input logic          rerun_req,
  input logic          swap_req,
  input logic          restart_req,
  input logic [CW-1:0] retry_cnt
);
  p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rerun_req, swap_req, restart_req}));

  p_rerun_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rerun_req |=> !rerun_req);

  p_swap_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req |=> !swap_req && !restart_req);

  p_restart_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req && !restart_done |=> restart_req);

  p_restart_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req && restart_done |=> !restart_req && retry_cnt == '0);

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(retry_cnt) |-> (retry_cnt == '0) || (retry_cnt == $past(retry_cnt) + 1'b1));
endmodule

bind tmr_recovery_ctrl tmr_recovery_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart_done(restart_done),
  .rerun_req(rerun_req), .swap_req(swap_req), .restart_req(restart_req),
  .retry_cnt(retry_cnt)
);

// File: tb/test_tmr_recovery_ctrl.sv
`timescale 1ns/1ps
module test_tmr_recovery_ctrl;
  localparam int CW = 4;
  localparam int KW = 8;
  localparam int CMAX = (1 << CW) - 1;
  localparam int KMAX = (1 << KW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_retry_limit = '0;
  logic [KW-1:0] cfg_retry_cost = '0, cfg_swap_cost = '0;
  logic vote_valid = 1'b0, vote_agree = 1'b0, swap_done = 1'b0, restart_done = 1'b0;
  logic rerun_req, swap_req, restart_req;
  logic [CW-1:0] retry_cnt;

  int checks = 0, errors = 0;
  int m_lim, m_step, m_swap, m_cnt, m_acc, esc_cnt;

  always #2 clk = ~clk;

  tmr_recovery_ctrl #(.CW(CW), .KW(KW)) i_tmr_recovery_ctrl (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_one(string req);
    chk(req, int'(rerun_req) + int'(swap_req) + int'(restart_req) <= 1, 1);
  endtask

  function automatic bit will_escalate(int c, int a);
    return (c + 1 > m_lim) || (a + m_step > m_swap);
  endfunction

  function automatic bit cost_cause(int c);
    return !(c + 1 > m_lim);
  endfunction

  task automatic do_reset(int lim, int step, int swp);
    rst_n = 1'b0;
    cfg_retry_limit = CW'(lim); cfg_retry_cost = KW'(step); cfg_swap_cost = KW'(swp);
    m_lim = lim; m_step = step; m_swap = swp; m_cnt = 0; m_acc = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(rerun_req) + int'(swap_req) + int'(restart_req), 0);
    rst_n = 1'b1;
    cfg_retry_limit = CW'($urandom); cfg_retry_cost = KW'($urandom); cfg_swap_cost = KW'($urandom);
    @(negedge clk);
    chk("R1", int'(rerun_req) + int'(swap_req) + int'(restart_req), 0);
    chk("R1", int'(retry_cnt), 0);
  endtask

  task automatic strobe(bit agree);
    @(negedge clk); vote_valid = 1'b1; vote_agree = agree;
    @(negedge clk); vote_valid = 1'b0;
  endtask

  task automatic swap_sequence();
    @(negedge clk);
    chk("R5", int'(swap_req), 0);
    if ($urandom % 2) begin
      strobe(1'b0);
      chk("R9", int'(rerun_req) + int'(swap_req) + int'(restart_req), 0);
      chk("R9", int'(retry_cnt), m_cnt);
    end
    repeat ($urandom % 3) @(negedge clk);
    swap_done = 1'b1; @(negedge clk); swap_done = 1'b0;
    chk("R7", int'(restart_req), 1);
    chk_one("R10");
    if ($urandom % 2) begin
      strobe($urandom % 2 == 1);
      chk("R9", int'(restart_req), 1);
      chk("R9", int'(retry_cnt), m_cnt);
    end
    repeat ($urandom % 3) @(negedge clk);
    chk("R7", int'(restart_req), 1);
    restart_done = 1'b1; @(negedge clk); restart_done = 1'b0;
    chk("R7", int'(restart_req), 0);
    chk("R7", int'(retry_cnt), 0);
    m_cnt = 0; m_acc = 0;
  endtask

  task automatic incident(int agree_pct);
    bit esc, agree, by_cost;
    strobe(1'b0);
    chk("R2", int'(rerun_req), 1);
    chk("R2", int'(retry_cnt), 0);
    while (1) begin
      @(negedge clk);
      chk("R2", int'(rerun_req), 0);
      repeat ($urandom % 3) @(negedge clk);
      agree = int'($urandom % 100) < agree_pct;
      if (agree) begin
        strobe(1'b1);
        m_cnt = 0; m_acc = 0;
        chk("R3", int'(retry_cnt), 0);
        chk("R3", int'(rerun_req) + int'(swap_req) + int'(restart_req), 0);
        return;
      end
      esc = will_escalate(m_cnt, m_acc);
      by_cost = cost_cause(m_cnt);
      m_cnt = (m_cnt + 1 > CMAX) ? CMAX : m_cnt + 1;
      m_acc = (m_acc + m_step > KMAX) ? KMAX : m_acc + m_step;
      strobe(1'b0);
      chk("R4", int'(retry_cnt), m_cnt);
      chk_one("R10");
      if (esc) begin
        esc_cnt = int'(retry_cnt);
        chk(by_cost ? "R6" : "R5", int'(swap_req), 1);
        chk(by_cost ? "R6" : "R5", int'(rerun_req), 0);
        swap_sequence();
        return;
      end
      chk("R4", int'(rerun_req), 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // Count-limited escalation (R5).
    do_reset(2, 0, 255);
    incident(0);
    chk("R5", esc_cnt, 3);
    // Cost-limited escalation; inputs scrambled after reset (R6, R8).
    do_reset(15, 100, 250);
    incident(0);
    chk("R8", esc_cnt, 3);
    // Zero limit: first failed re-execution escalates.
    do_reset(0, 0, 255);
    incident(0);
    chk("R5", esc_cnt, 1);
    // Agreeing vote while idle is ignored (R11).
    strobe(1'b1);
    chk("R11", int'(rerun_req) + int'(swap_req) + int'(restart_req), 0);
    chk("R11", int'(retry_cnt), 0);
    // Saturating count at top limit with zero cost.
    do_reset(CMAX, 0, 255);
    incident(0);
    chk("R4", esc_cnt, CMAX);
    // Random mix.
    for (int e = 0; e < 12; e++) begin
      do_reset(int'($urandom % (CMAX + 1)), int'($urandom % 80), int'($urandom % (KMAX + 1)));
      for (int k = 0; k < 6; k++) begin
        if ($urandom % 4 == 0) begin
          strobe(1'b1);
          chk("R11", int'(rerun_req), 0);
        end
        incident(30);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule